// File: doc/BRIEF.md
# Three-Level Lookahead 64-bit Adder

This block adds two 64-bit operands and a carry input in a single combinational path. It produces a 64-bit sum and a carry output. It does not ripple the carry from bit to bit. Instead, every carry comes from a tree of four-way lookahead units.

- Each bit forms a generate term (AND of the operand bits) and a propagate term (OR of the operand bits).
- Each 4-bit group turns its bit terms, and the carry coming into the group, into its three internal carries. The group also reports a group generate and a group propagate.
- A second tier of the same unit combines four groups into a 16-bit span.
- A third tier combines the four spans. It produces the carries into bits 16, 32 and 48 together, and the final carry out of bit 63.

Each sum bit is the XOR of the two operand bits, XORed again with the carry into that bit. This XOR term is kept separate from the OR-based propagate term used by the lookahead tree.

The adder is meant for a datapath that needs a full-width sum in one cycle with a logarithmic carry depth. It has no clock and no state. The outputs follow the inputs after the combinational delay.

Top module: `cla64_adder`

## Requirements
- R1: For any operands and carry input, `sum_o` equals (`a_i` + `b_i` + `cin_i`) modulo 2^64, and `cout_o` equals bit 64 of that 65-bit total.
- R2: With all operand bits zero, `sum_o` equals the carry input in bit 0 with zeros elsewhere, and `cout_o` is 0.
- R3: When every bit position propagates (a_i XOR b_i is all ones) and `cin_i` is 1, the carry passes through all 64 bits: `sum_o` is 0 and `cout_o` is 1. With `cin_i` 0 in the same case, `sum_o` is all ones and `cout_o` is 0.
- R4: A carry produced in the top bit of a 4-bit group reaches the next group. 0x000000000000000F plus 1 gives 0x0000000000000010.
- R5: A carry produced at the top of a 16-bit span reaches the next span. Adding 1 to a value whose low 16, 32 or 48 bits are all ones clears those bits and sets the bit just above them.
- R6: Alternating operands 0xAAAAAAAAAAAAAAAA and 0x5555555555555555 give all ones with `cin_i` 0, and zero with carry out 1 with `cin_i` 1.
- R7: When both operands have bit 63 set, `cout_o` is 1. When neither operand has bit 63 set, `cout_o` is 0.
- R8: Two all-ones operands with carry input c give a sum of all ones minus (1 − c), and `cout_o` is 1.
- R9: Swapping `a_i` and `b_i` leaves `sum_o` and `cout_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 64 | Sum modulo 2^64 |
| cout_o | output | 1 | Carry out of bit 63 |

## Verification
A wrong group generate or propagate term shows as a sum that is off by a power of two at a 4-bit or 16-bit boundary. The top-level carry out goes wrong with it. Because the block is purely combinational, the error is visible at the outputs in the same cycle the operands are applied. The directed cases therefore place carry chains that start or end exactly at each lookahead boundary. The random cases compare every result against a bit-serial ripple model.

// File: rtl/cla_pkg.sv
package cla_pkg;
    localparam int CLA_WIDTH = 64;  // operand width handled by the tree
    localparam int CLA_RADIX = 4;   // fan-in of every lookahead unit
endpackage

// File: rtl/cla_bit_terms.sv
// Per-bit carry terms: generate (AND), propagate (OR) and half-sum (XOR).
module cla_bit_terms #(
    parameter int WIDTH = cla_pkg::CLA_WIDTH
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] gen_o,
    output logic [WIDTH-1:0] prop_o,
    output logic [WIDTH-1:0] hsum_o
);
    always_comb begin
        gen_o  = a_i & b_i;
        prop_o = a_i | b_i;
        hsum_o = a_i ^ b_i;
    end
endmodule

// File: rtl/cla_look4.sv
// Four-way lookahead unit, reused at every tier of the tree.
// Each internal carry is a flat sum of products: no carry ripples inside the unit.
module cla_look4 (
    input  logic [3:0] g_i,
    input  logic [3:0] p_i,
    input  logic       cin_i,
    output logic [3:1] carry_o,
    output logic       grp_g_o,
    output logic       grp_p_o
);
    always_comb begin
        carry_o[1] = g_i[0]
                   | (p_i[0] & cin_i);
        carry_o[2] = g_i[1]
                   | (p_i[1] & g_i[0])
                   | (p_i[1] & p_i[0] & cin_i);
        carry_o[3] = g_i[2]
                   | (p_i[2] & g_i[1])
                   | (p_i[2] & p_i[1] & g_i[0])
                   | (p_i[2] & p_i[1] & p_i[0] & cin_i);
        grp_g_o    = g_i[3]
                   | (p_i[3] & g_i[2])
                   | (p_i[3] & p_i[2] & g_i[1])
                   | (p_i[3] & p_i[2] & p_i[1] & g_i[0]);
        grp_p_o    = &p_i;
    end
endmodule

// File: rtl/cla64_adder.sv
// 64-bit adder whose carries come from three nested tiers of 4-way lookahead.
module cla64_adder #(
    parameter int WIDTH = cla_pkg::CLA_WIDTH
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);
    localparam int RADIX  = cla_pkg::CLA_RADIX;
    localparam int SPAN1  = RADIX;          // bits per first-tier group
    localparam int SPAN2  = RADIX * RADIX;  // bits per second-tier span
    localparam int GROUPS = WIDTH / SPAN1;
    localparam int SPANS  = WIDTH / SPAN2;

    logic [WIDTH-1:0]  bit_g, bit_p, bit_x;
    logic [GROUPS-1:0] grp_g, grp_p;
    logic [SPANS-1:0]  spn_g, spn_p;
    logic              top_g, top_p;
    wire  [WIDTH:0]    carry;  // carry[i] enters bit i

    cla_bit_terms #(.WIDTH(WIDTH)) terms_i (
        .a_i    (a_i),
        .b_i    (b_i),
        .gen_o  (bit_g),
        .prop_o (bit_p),
        .hsum_o (bit_x)
    );

    assign carry[0] = cin_i;

    // Tier 1: carries inside each 4-bit group.
    for (genvar k = 0; k < GROUPS; k++) begin : g_tier1
        cla_look4 look_i (
            .g_i     (bit_g[SPAN1*k +: SPAN1]),
            .p_i     (bit_p[SPAN1*k +: SPAN1]),
            .cin_i   (carry[SPAN1*k]),
            .carry_o (carry[SPAN1*k+3 : SPAN1*k+1]),
            .grp_g_o (grp_g[k]),
            .grp_p_o (grp_p[k])
        );
    end

    // Tier 2: carries into the groups of each 16-bit span.
    for (genvar s = 0; s < SPANS; s++) begin : g_tier2
        wire [3:1] c2;
        cla_look4 look_i (
            .g_i     (grp_g[RADIX*s +: RADIX]),
            .p_i     (grp_p[RADIX*s +: RADIX]),
            .cin_i   (carry[SPAN2*s]),
            .carry_o (c2),
            .grp_g_o (spn_g[s]),
            .grp_p_o (spn_p[s])
        );
        for (genvar j = 1; j < RADIX; j++) begin : g_tap
            assign carry[SPAN2*s + SPAN1*j] = c2[j];
        end
    end

    // Tier 3: carries into bits 16, 32 and 48, plus the top-level terms.
    wire [3:1] c3;
    cla_look4 tier3_i (
        .g_i     (spn_g),
        .p_i     (spn_p),
        .cin_i   (cin_i),
        .carry_o (c3),
        .grp_g_o (top_g),
        .grp_p_o (top_p)
    );
    for (genvar j = 1; j < RADIX; j++) begin : g_tap3
        assign carry[SPAN2*j] = c3[j];
    end
    assign carry[WIDTH] = top_g | (top_p & cin_i);

    always_comb begin
        sum_o  = bit_x ^ carry[WIDTH-1:0];
        cout_o = carry[WIDTH];
    end
endmodule

// File: rtl/cla64_adder_chk.sv
// Checker for cla64_adder. The block has no clock, so every check is an immediate assertion.
module cla64_adder_chk (
    input logic [63:0] a_i,
    input logic [63:0] b_i,
    input logic        cin_i,
    input logic [63:0] sum_o,
    input logic        cout_o
);
    logic [64:0] total;

    always_comb begin
        total = {1'b0, a_i} + {1'b0, b_i} + {64'd0, cin_i};
        if (!$isunknown({a_i, b_i, cin_i, sum_o, cout_o})) begin
            a_r1_sum_matches: assert ({cout_o, sum_o} == total);
            if (a_i == 64'd0 && b_i == 64'd0) begin
                a_r2_zero_in: assert (sum_o == {63'd0, cin_i} && !cout_o);
            end
            if ((a_i ^ b_i) == {64{1'b1}} && cin_i) begin
                a_r3_full_chain: assert (sum_o == 64'd0 && cout_o);
            end
            if (a_i[63] && b_i[63]) begin
                a_r7_msb_gen: assert (cout_o);
            end
            if (!a_i[63] && !b_i[63]) begin
                a_r7_msb_kill: assert (!cout_o);
            end
        end
    end
endmodule

bind cla64_adder cla64_adder_chk chk_i (
    .a_i    (a_i),
    .b_i    (b_i),
    .cin_i  (cin_i),
    .sum_o  (sum_o),
    .cout_o (cout_o)
);

// File: tb/cla64_adder_tb_top.sv
module cla64_adder_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] a, b;
    logic        cin;
    logic [63:0] sum;
    logic        cout;
    int          n_chk  = 0;
    int          n_fail = 0;
    bit          done   = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    cla64_adder dut_i (
        .a_i    (a),
        .b_i    (b),
        .cin_i  (cin),
        .sum_o  (sum),
        .cout_o (cout)
    );

    // Bit-serial ripple reference, independent of the lookahead structure.
    function automatic logic [64:0] ripple(input logic [63:0] x, input logic [63:0] y,
                                           input logic c0);
        logic [63:0] s;
        logic        c;
        c = c0;
        for (int i = 0; i < 64; i++) begin
            s[i] = x[i] ^ y[i] ^ c;
            c    = (x[i] & y[i]) | (c & (x[i] ^ y[i]));
        end
        return {c, s};
    endfunction

    // Apply operands on a rising edge, then sample on the following falling edge.
    task automatic apply(input logic [63:0] x, input logic [63:0] y, input logic c0);
        @(posedge clk);
        a   = x;
        b   = y;
        cin = c0;
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [64:0] exp);
        n_chk++;
        if ({cout, sum} !== exp) begin
            n_fail++;
            $display("FAIL %s: a=%h b=%h cin=%b got %b_%h exp %b_%h",
                     req, a, b, cin, cout, sum, exp[64], exp[63:0]);
        end
    endtask

    task automatic t_zero();  // R2
        apply(64'd0, 64'd0, 1'b0); check("R2", 65'd0);
        apply(64'd0, 64'd0, 1'b1); check("R2", 65'd1);
    endtask

    task automatic t_full_chain();  // R3
        apply({64{1'b1}}, 64'd0, 1'b1);               check("R3", {1'b1, 64'd0});
        apply(64'hF0F0_0F0F_FF00_00FF, 64'h0F0F_F0F0_00FF_FF00, 1'b0);
        check("R3", {1'b0, {64{1'b1}}});
    endtask

    task automatic t_group_edge();  // R4
        apply(64'hF, 64'd1, 1'b0);     check("R4", 65'h10);
        apply(64'hF0, 64'h10, 1'b0);   check("R4", 65'h100);
    endtask

    task automatic t_span_edge();  // R5
        apply(64'h0000_0000_0000_FFFF, 64'd1, 1'b0); check("R5", 65'h1_0000);
        apply(64'h0000_0000_FFFF_FFFF, 64'd0, 1'b1); check("R5", 65'h1_0000_0000);
        apply(64'h0000_FFFF_FFFF_FFFF, 64'd1, 1'b0); check("R5", 65'h1_0000_0000_0000);
    endtask

    task automatic t_alternate();  // R6
        apply(64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555, 1'b0);
        check("R6", {1'b0, {64{1'b1}}});
        apply(64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555, 1'b1);
        check("R6", {1'b1, 64'd0});
    endtask

    task automatic t_msb();  // R7
        apply(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0);
        check("R7", {1'b1, 64'd0});
        apply(64'h7FFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF, 1'b1);
        check("R7", {1'b0, 64'hFFFF_FFFF_FFFF_FFFF});
    endtask

    task automatic t_all_ones();  // R8
        apply({64{1'b1}}, {64{1'b1}}, 1'b0); check("R8", {1'b1, 64'hFFFF_FFFF_FFFF_FFFE});
        apply({64{1'b1}}, {64{1'b1}}, 1'b1); check("R8", {1'b1, {64{1'b1}}});
    endtask

    task automatic t_random();  // R1 and R9
        for (int i = 0; i < 400; i++) begin
            logic [63:0] x, y;
            logic        c0;
            x  = {$urandom, $urandom};
            y  = {$urandom, $urandom};
            c0 = 1'($urandom);
            if (i % 4 == 1) y = ~x;  // long propagate chains
            apply(x, y, c0); check("R1", ripple(x, y, c0));
            apply(y, x, c0); check("R9", ripple(x, y, c0));
        end
    endtask

    initial begin
        a = 64'd0; b = 64'd0; cin = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk); check("R2", 65'd0);  // idle state after reset
        t_zero();
        t_full_chain();
        t_group_edge();
        t_span_edge();
        t_alternate();
        t_msb();
        t_all_ones();
        t_random();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (50000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog: got timeout exp completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule